// File: doc/BRIEF.md
# External Bus Cycle Termination Controller

This block runs one external bus cycle at a time on behalf of a bus master. A request presents an address, a direction, an operand size and a function code. The controller launches the cycle and then waits for it to end. It resolves the termination inputs with fixed priorities. It returns a one-cycle done pulse together with a status code and the port width reported by the addressed device. The termination inputs are a two-wire data-size acknowledge, an autovector acknowledge, a bus error and halt.

An internal bus monitor ends a cycle that no device answers. Halt gives single-cycle stepping: after a cycle ends under halt, the data bus floats and the strobe drops, but address and control stay frozen until halt is released. Halt together with bus error produces a retry of the same cycle. Accesses that stay inside the chip bypass halt completely. When another master owns the bus, the monitor and the autovector response are switched off.

Top module: `xbus_term_ctrl`

## Requirements
- R1: An external cycle that receives no acknowledge, autovector or bus error ends with status bus error. The done pulse is first seen exactly L clock edges after the edge that accepted the request, where L is the effective timeout limit.
- R2: If bus error and an acknowledge are both active in the same cycle while halt is low, the cycle reports bus error (status 2'b10), never normal completion.
- R3: Bus error with halt ends the attempt with status retry (2'b11). The strobe then stays low and address, function code, size and direction stay unchanged while halt is high. One edge after halt is released, the same cycle runs again with the same fields.
- R4: A cycle that terminates while halt is high still pulses done. After that, strobe and data drive are low and the address, function code, size and direction outputs hold their values until halt is released.
- R5: While halt is high and no cycle is running, no new external cycle starts and the interrupt-take output stays low. irq_take_o is high only when the controller is idle, halt is low and irq_pend_i is high.
- R6: A request with int_only_i high completes with done and status normal one edge after acceptance, whether or not halt is high. It is accepted when idle or halted, and it leaves the held external outputs unchanged.
- R7: The autovector input ends a cycle with status 2'b01 only when the latched function code is 3'b111. With any other function code it has no effect.
- R8: While ext_master_i is high, the bus monitor never times out and the autovector input is ignored.
- R9: The acknowledge pair ack_n_i is active low. 2'b11 means wait. 2'b10 ends the cycle as an 8-bit port (port16_o=0). 2'b01 and 2'b00 end it as a 16-bit port (port16_o=1).
- R10: The effective limit L is tmo_lim_i clamped to the range 8..64, and the monitor count restarts at the start of every cycle and every retry.
- R11: Status encodings are 00 normal, 01 autovector, 10 bus error, 11 retry. done_o lasts one cycle. After reset, done_o, strobe_o and busy_o are low.
- R12: strobe_o is high throughout a running external cycle. data_oe_o is high during a running write cycle (rd_wr_i=0) and low during reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| int_only_i | input | 1 | Request targets on-chip resources only |
| addr_i | input | AW | Request address |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| size_i | input | 2 | Operand size |
| fc_i | input | 3 | Function code (3'b111 = interrupt acknowledge) |
| ack_n_i | input | 2 | Active-low data-size acknowledge pair |
| avec_i | input | 1 | Autovector acknowledge |
| berr_i | input | 1 | Bus error |
| halt_i | input | 1 | Halt |
| ext_master_i | input | 1 | Another master owns the bus |
| irq_pend_i | input | 1 | Interrupt request pending |
| tmo_lim_i | input | 7 | Bus monitor limit in clocks |
| addr_o | output | AW | Held cycle address |
| rd_wr_o | output | 1 | Held direction |
| size_o | output | 2 | Held size |
| fc_o | output | 3 | Held function code |
| strobe_o | output | 1 | Cycle strobe |
| data_oe_o | output | 1 | Data bus drive enable |
| busy_o | output | 1 | Controller not idle |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Completion status |
| port16_o | output | 1 | Reported port is 16 bits wide |
| irq_take_o | output | 1 | Interrupt may be acted on |

## Verification
The strobe rises one edge after a request is accepted. Done, status and port width appear one edge after the edge that samples a termination input. A timeout appears L edges after acceptance. Leaving a halted hold takes one edge to reach idle and one more to start a pending cycle. The bench drives and samples on the falling edge, advances one rising edge per step, and counts edges explicitly when it sweeps the timeout limit over all values from 0 to 70.

// File: rtl/xbt_pkg.sv
package xbt_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'b00,
    ST_AVEC   = 2'b01,
    ST_BERR   = 2'b10,
    ST_RETRY  = 2'b11
  } xbt_status_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_HOLD,
    S_REWAIT
  } xbt_state_e;

  typedef struct packed {
    logic        hit;
    xbt_status_e code;
    logic        port16;
  } xbt_term_t;
endpackage

// File: rtl/xbt_bus_monitor.sv
module xbt_bus_monitor #(
  parameter int TMO_MIN = 8,
  parameter int TMO_MAX = 64,
  parameter int LIMW    = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            run_i,
  input  logic            enable_i,
  input  logic [LIMW-1:0] lim_i,
  output logic            expired_o
);
  localparam int CW = $clog2(TMO_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim_eff;

  always_comb begin
    if (lim_i < LIMW'(TMO_MIN))      lim_eff = CW'(TMO_MIN);
    else if (lim_i > LIMW'(TMO_MAX)) lim_eff = CW'(TMO_MAX);
    else                             lim_eff = CW'(lim_i);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                     cnt_d = '0;
    else if (run_i && cnt_q != '1) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = enable_i && run_i && (cnt_q >= lim_eff - CW'(1));
endmodule

// File: rtl/xbt_term_resolve.sv
module xbt_term_resolve
  import xbt_pkg::*;
#(
  parameter logic [2:0] IACK_FC = 3'b111
) (
  input  logic       berr_i,
  input  logic       halt_i,
  input  logic       tmo_i,
  input  logic [1:0] ack_n_i,
  input  logic       avec_i,
  input  logic [2:0] fc_i,
  input  logic       ext_master_i,
  output xbt_term_t  term_o
);
  always_comb begin
    term_o.hit    = 1'b0;
    term_o.code   = ST_NORMAL;
    term_o.port16 = 1'b1;
    if (berr_i && halt_i) begin
      term_o.hit  = 1'b1;
      term_o.code = ST_RETRY;
    end else if (berr_i || tmo_i) begin
      term_o.hit  = 1'b1;
      term_o.code = ST_BERR;
    end else if (ack_n_i != 2'b11) begin
      term_o.hit    = 1'b1;
      term_o.code   = ST_NORMAL;
      term_o.port16 = (ack_n_i != 2'b10);
    end else if (avec_i && fc_i == IACK_FC && !ext_master_i) begin
      term_o.hit  = 1'b1;
      term_o.code = ST_AVEC;
    end
  end
endmodule

// File: rtl/xbus_term_ctrl.sv
module xbus_term_ctrl
  import xbt_pkg::*;
#(
  parameter int         AW      = 16,
  parameter int         TMO_MIN = 8,
  parameter int         TMO_MAX = 64,
  parameter logic [2:0] IACK_FC = 3'b111
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          int_only_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_wr_i,
  input  logic [1:0]    size_i,
  input  logic [2:0]    fc_i,
  input  logic [1:0]    ack_n_i,
  input  logic          avec_i,
  input  logic          berr_i,
  input  logic          halt_i,
  input  logic          ext_master_i,
  input  logic          irq_pend_i,
  input  logic [6:0]    tmo_lim_i,
  output logic [AW-1:0] addr_o,
  output logic          rd_wr_o,
  output logic [1:0]    size_o,
  output logic [2:0]    fc_o,
  output logic          strobe_o,
  output logic          data_oe_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    status_o,
  output logic          port16_o,
  output logic          irq_take_o
);
  xbt_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          rw_q;
  logic [1:0]    size_q;
  logic [2:0]    fc_q;
  logic          done_q, done_d;
  xbt_status_e   status_q, status_d;
  logic          port16_q, port16_d;
  logic          load_en, int_go, tmo_exp, run, restart;
  xbt_term_t     term;

  assign run     = (state_q == S_RUN);
  assign restart = (state_q != S_RUN) && (state_d == S_RUN);
  assign load_en = (state_q == S_IDLE) && (state_d == S_RUN);
  assign int_go  = req_i && int_only_i && (state_q == S_IDLE || state_q == S_HOLD);

  xbt_bus_monitor #(.TMO_MIN(TMO_MIN), .TMO_MAX(TMO_MAX), .LIMW(7)) u_mon (
    .clk(clk), .rst_n(rst_n), .clr_i(restart), .run_i(run),
    .enable_i(!ext_master_i), .lim_i(tmo_lim_i), .expired_o(tmo_exp)
  );

  xbt_term_resolve #(.IACK_FC(IACK_FC)) u_res (
    .berr_i(berr_i), .halt_i(halt_i), .tmo_i(tmo_exp), .ack_n_i(ack_n_i),
    .avec_i(avec_i), .fc_i(fc_q), .ext_master_i(ext_master_i), .term_o(term)
  );

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (req_i && !int_only_i && !halt_i) state_d = S_RUN;
      S_RUN:    if (term.hit) begin
                  if (term.code == ST_RETRY) state_d = S_REWAIT;
                  else if (halt_i)           state_d = S_HOLD;
                  else                       state_d = S_IDLE;
                end
      S_HOLD:   if (!halt_i) state_d = S_IDLE;
      S_REWAIT: if (!halt_i) state_d = S_RUN;
      default:  state_d = S_IDLE;
    endcase
  end

  always_comb begin
    done_d   = int_go || (run && term.hit);
    status_d = int_go ? ST_NORMAL : term.code;
    port16_d = int_go ? 1'b1 : term.port16;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      done_q   <= 1'b0;
      status_q <= ST_NORMAL;
      port16_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      done_q   <= done_d;
      status_q <= status_d;
      port16_q <= port16_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rw_q   <= 1'b1;
      size_q <= '0;
      fc_q   <= '0;
    end else if (load_en) begin
      addr_q <= addr_i;
      rw_q   <= rd_wr_i;
      size_q <= size_i;
      fc_q   <= fc_i;
    end
  end

  assign addr_o     = addr_q;
  assign rd_wr_o    = rw_q;
  assign size_o     = size_q;
  assign fc_o       = fc_q;
  assign strobe_o   = run;
  assign data_oe_o  = run && !rw_q;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign status_o   = status_q;
  assign port16_o   = port16_q;
  assign irq_take_o = irq_pend_i && (state_q == S_IDLE) && !halt_i;

  p_timeout_berr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tmo_exp && !berr_i) |=> (done_o && status_o == ST_BERR));

  p_berr_over_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && berr_i && !halt_i) |=> (done_o && status_o == ST_BERR));

  p_frozen_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HOLD || state_q == S_REWAIT) |=> $stable({addr_o, fc_o, size_o, rd_wr_o}));

  p_halt_blocks_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && halt_i) |=> !strobe_o);

  p_avec_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fc_q != IACK_FC && ack_n_i == 2'b11 && !berr_i && !tmo_exp) |=> !done_o);
endmodule

// File: tb/xbus_term_ctrl_bench.sv
`timescale 1ns/1ps
module xbus_term_ctrl_bench;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic req, int_only, rw, avec, berr, halt, ext_master, irq_pend;
  logic [AW-1:0] addr;
  logic [1:0] size, ack_n;
  logic [2:0] fc;
  logic [6:0] tmo_lim;
  logic [AW-1:0] addr_o;
  logic rd_wr_o, strobe_o, data_oe_o, busy_o, done_o, port16_o, irq_take_o;
  logic [1:0] size_o, status_o;
  logic [2:0] fc_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  xbus_term_ctrl #(.AW(AW)) u_xbus_term_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .int_only_i(int_only), .addr_i(addr),
    .rd_wr_i(rw), .size_i(size), .fc_i(fc), .ack_n_i(ack_n), .avec_i(avec),
    .berr_i(berr), .halt_i(halt), .ext_master_i(ext_master), .irq_pend_i(irq_pend),
    .tmo_lim_i(tmo_lim), .addr_o(addr_o), .rd_wr_o(rd_wr_o), .size_o(size_o),
    .fc_o(fc_o), .strobe_o(strobe_o), .data_oe_o(data_oe_o), .busy_o(busy_o),
    .done_o(done_o), .status_o(status_o), .port16_o(port16_o), .irq_take_o(irq_take_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // request accepted at the next rising edge; returns at the falling edge after it
  task automatic begin_cycle(input logic [AW-1:0] a, input logic r, input logic [2:0] f);
    req = 1'b1; int_only = 1'b0; addr = a; rw = r; fc = f; size = 2'b01;
    step();
    req = 1'b0;
  endtask

  task automatic ack_end(input logic [1:0] code, input int exp_p16, input string tag);
    ack_n = code;
    step();
    ack_n = 2'b11;
    chk(done_o == 1'b1, tag, done_o, 1);
    chk(status_o == 2'b00, tag, status_o, 0);
    chk(port16_o == exp_p16[0], tag, port16_o, exp_p16);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 0; int_only = 0; rw = 1; avec = 0; berr = 0; halt = 0;
    ext_master = 0; irq_pend = 0; addr = '0; size = 0; ack_n = 2'b11; fc = 3'b101;
    tmo_lim = 7'd64;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!done_o && !strobe_o && !busy_o, "R11 reset", {done_o, strobe_o, busy_o}, 0);

    // R9 R12: every acknowledge code x direction, varying wait states
    for (int rv = 0; rv < 2; rv++) begin
      for (int ac = 0; ac < 3; ac++) begin
        logic [1:0] code;
        code = (ac == 0) ? 2'b10 : (ac == 1) ? 2'b01 : 2'b00;
        begin_cycle(AW'(16'h1200 + ac * 2 + rv), rv[0], 3'b101);
        for (int w = 0; w < ac + 1; w++) begin
          chk(strobe_o == 1'b1, "R12 strobe", strobe_o, 1);
          chk(data_oe_o == !rv[0], "R12 data drive", data_oe_o, !rv[0]);
          chk(done_o == 1'b0, "R9 wait", done_o, 0);
          step();
        end
        ack_end(code, (code == 2'b10) ? 0 : 1, "R9 ack code");
        chk(!busy_o && !strobe_o, "R12 idle after", strobe_o, 0);
      end
    end

    // R7 autovector on interrupt-acknowledge code
    begin_cycle(16'h00F0, 1'b1, 3'b111);
    avec = 1'b1;
    step();
    avec = 1'b0;
    chk(done_o && status_o == 2'b01, "R7 avec iack", status_o, 1);

    // R7 autovector ignored on other codes
    begin_cycle(16'h00F2, 1'b1, 3'b101);
    avec = 1'b1;
    for (int w = 0; w < 5; w++) begin
      step();
      chk(done_o == 1'b0, "R7 avec ignored", done_o, 0);
    end
    avec = 1'b0;
    ack_end(2'b01, 1, "R7 later ack");

    // R2 bus error beats acknowledge
    begin_cycle(16'h0300, 1'b0, 3'b101);
    berr = 1'b1; ack_n = 2'b01;
    step();
    berr = 1'b0; ack_n = 2'b11;
    chk(done_o && status_o == 2'b10, "R2 berr with ack", status_o, 2);

    // R1 R10 timeout sweep over limits, with clamping
    for (int lim = 0; lim <= 70; lim++) begin
      int k, expk;
      expk = (lim < 8) ? 8 : (lim > 64) ? 64 : lim;
      tmo_lim = 7'(lim);
      begin_cycle(AW'(lim), 1'b1, 3'b101);
      k = 0;
      do begin
        step();
        k++;
      end while (!done_o && k < 100);
      chk(k == expk, "R1 R10 timeout edges", k, expk);
      chk(status_o == 2'b10, "R1 timeout status", status_o, 2);
    end
    tmo_lim = 7'd64;

    // R8 external master: no timeout, autovector ignored
    ext_master = 1'b1;
    begin_cycle(16'h0400, 1'b1, 3'b111);
    avec = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int w = 0; w < 80; w++) begin
        step();
        if (done_o) seen++;
      end
      chk(seen == 0, "R8 no monitor no avec", seen, 0);
    end
    avec = 1'b0;
    ack_end(2'b01, 1, "R8 ack still ends");
    ext_master = 1'b0;

    // R3 retry on halt plus bus error
    begin_cycle(16'hA5A5, 1'b0, 3'b110);
    berr = 1'b1; halt = 1'b1;
    step();
    berr = 1'b0;
    chk(done_o && status_o == 2'b11, "R3 retry status", status_o, 3);
    for (int w = 0; w < 4; w++) begin
      step();
      chk(!strobe_o && busy_o, "R3 waits under halt", strobe_o, 0);
      chk(addr_o == 16'hA5A5 && fc_o == 3'b110 && !rd_wr_o, "R3 fields held", addr_o, 16'hA5A5);
    end
    halt = 1'b0;
    step();
    chk(strobe_o && data_oe_o, "R3 rerun strobe", strobe_o, 1);
    chk(addr_o == 16'hA5A5 && fc_o == 3'b110 && size_o == 2'b01, "R3 rerun fields", addr_o, 16'hA5A5);
    ack_end(2'b01, 1, "R3 rerun completes");

    // R4 R5 R6 halt stepping
    irq_pend = 1'b1;
    begin_cycle(16'h5B5B, 1'b1, 3'b101);
    chk(irq_take_o == 1'b0, "R5 irq not idle", irq_take_o, 0);
    halt = 1'b1;
    ack_end(2'b10, 0, "R4 done under halt");
    for (int w = 0; w < 3; w++) begin
      step();
      chk(!strobe_o && !data_oe_o, "R4 bus floated", strobe_o, 0);
      chk(addr_o == 16'h5B5B && rd_wr_o, "R4 address held", addr_o, 16'h5B5B);
      chk(irq_take_o == 1'b0, "R5 irq blocked", irq_take_o, 1'b0);
    end
    req = 1'b1; int_only = 1'b1; addr = 16'hFFFF;
    step();
    req = 1'b0; int_only = 1'b0;
    chk(done_o && status_o == 2'b00, "R6 internal under halt", done_o, 1);
    chk(addr_o == 16'h5B5B, "R6 held address kept", addr_o, 16'h5B5B);
    req = 1'b1; addr = 16'h0C0C; rw = 1'b1; fc = 3'b101;
    for (int w = 0; w < 4; w++) begin
      step();
      chk(!strobe_o && addr_o == 16'h5B5B, "R5 no start while halted", addr_o, 16'h5B5B);
    end
    halt = 1'b0;
    step();
    chk(!strobe_o && !busy_o, "R4 idle after release", busy_o, 0);
    chk(irq_take_o == 1'b1, "R5 irq when idle", irq_take_o, 1);
    step();
    req = 1'b0; irq_pend = 1'b0;
    chk(strobe_o && addr_o == 16'h0C0C, "R5 pending cycle starts", addr_o, 16'h0C0C);
    ack_end(2'b01, 1, "R5 pending completes");

    // R6 internal access from idle while halt is high
    halt = 1'b1;
    req = 1'b1; int_only = 1'b1;
    step();
    req = 1'b0; int_only = 1'b0;
    chk(done_o && status_o == 2'b00 && !strobe_o, "R6 internal idle", done_o, 1);
    step();
    chk(done_o == 1'b0, "R11 done one cycle", done_o, 0);
    halt = 1'b0;
    step();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule